// File: doc/BRIEF.md
# I2C No-Stretch Slave Overrun Handler

This block sits between the byte shifter of an I2C slave and the software-facing receive and transmit data registers. It is meant for the configuration in which the slave may not hold SCL low. In that configuration the bus does not wait for software. A byte that completes while the previous received byte is still unread has nowhere to go. A byte that must be shifted out before software has written one has no data.

The handler keeps a full flag for the receive register and an empty flag for the transmit register. When the handler is active and software is late, it drops the incoming byte and tells the shifter to answer with a NACK. On the transmit side it substitutes an all-ones filler byte. There is a separate rule for the first data byte after a stop has been seen. In every such case a sticky error flag is raised, and that flag drives an interrupt when the error interrupt is enabled. Bit timing on SCL/SDA and address matching belong to other blocks.

Top module: `i2c_ns_ovr`

## Requirements
- R1: Error handling is active only when `is_slave` and `cfg_nostretch` are both 1. In any other configuration no error is raised.
- R2: When active, a byte strobe (`rx_valid`) that arrives while `rx_full` is 1 and `sw_rd` is 0 in the same cycle discards the new byte. `rx_data` keeps the old byte.
- R3: A discarded received byte makes `rx_nack` 1 in the same cycle as its `rx_valid` strobe. In all other cycles `rx_nack` is 0.
- R4: When active, a transmit request with `tx_first`=1 and `stop_seen`=1 always raises the error. `tx_byte` is the transmit register if `tx_empty`=0, and 8'hFF otherwise.
- R5: When active, any other transmit request made while `tx_empty`=1 sends 8'hFF and raises the error. A request made while `tx_empty`=0 sends the register and raises no error.
- R6: `ovr_flag` is set in the cycle after any error and stays set until an `ovr_clr` pulse. If a set and a clear arrive together, the set wins.
- R7: `irq` equals `ovr_flag` AND `cfg_err_ie`.
- R8: After reset, `rx_full`=0, `tx_empty`=1, `rx_data`=0 and `ovr_flag`=0. A stored byte sets `rx_full` and `sw_rd` clears it; a read in the same cycle as a strobe frees the register for that byte. A transmit request sets `tx_empty` and `sw_wr` clears it; if both come in the same cycle, the write wins and its data is kept.
- R9: When inactive, every received byte is stored (with no NACK), and `tx_byte` is always the transmit register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_slave | input | 1 | Controller currently in slave role |
| cfg_nostretch | input | 1 | Clock stretching disabled |
| cfg_err_ie | input | 1 | Error interrupt enable |
| rx_valid | input | 1 | Shifter completed a received byte (one-cycle strobe) |
| rx_byte | input | 8 | Received byte from the shifter |
| sw_rd | input | 1 | Software reads the receive register |
| rx_data | output | 8 | Receive register contents |
| rx_full | output | 1 | Receive register holds unread data |
| rx_nack | output | 1 | Force NACK for the byte strobed this cycle |
| sw_wr | input | 1 | Software writes the transmit register |
| sw_wdata | input | 8 | Data written by software |
| tx_req | input | 1 | Shifter loads the next byte to send (one-cycle strobe) |
| tx_first | input | 1 | The requested byte is the first data byte of the transfer |
| stop_seen | input | 1 | Stop-detected status is set |
| tx_byte | output | 8 | Byte handed to the shifter on a request |
| tx_empty | output | 1 | Transmit register not written since the last load |
| ovr_clr | input | 1 | Clears the error flag |
| ovr_flag | output | 1 | Sticky overrun/underrun flag |
| irq | output | 1 | Error interrupt |

## Verification
Assertions check the following every cycle: a dropped byte leaves the receive register unchanged; a request leaves the transmit register empty unless it is written in the same cycle; every NACK is followed by a set flag; the flag stays set until it is cleared; the interrupt never rises without the flag; and nothing is flagged while the handler is inactive. Only the bench scenarios can show which byte is chosen in each transmit case, including the first-byte-after-stop rule with the register full or empty. The same holds for same-cycle read/strobe and write/request races, and for the way the interrupt follows its enable.

// File: rtl/ovr_pkg.sv
package ovr_pkg;

    typedef enum logic [0:0] {
        SRC_REG  = 1'b0,
        SRC_FILL = 1'b1
    } tx_src_e;

    typedef struct packed {
        tx_src_e src;
        logic    err;
    } tx_dec_t;

    // Decide where the next transmitted byte comes from and whether software was late.
    function automatic tx_dec_t tx_decide(input logic active, input logic empty,
                                          input logic first, input logic stop);
        tx_dec_t d;
        d.src = SRC_REG;
        d.err = 1'b0;
        if (active) begin
            if (first && stop) begin
                d.err = 1'b1;
                d.src = empty ? SRC_FILL : SRC_REG;
            end else if (empty) begin
                d.err = 1'b1;
                d.src = SRC_FILL;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/ovr_rx_track.sv
module ovr_rx_track #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          sw_rd,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          overrun
);
    logic still_full;
    logic store;

    always_comb begin
        still_full = rx_full && !sw_rd;
        overrun    = active && rx_valid && still_full;
        store      = rx_valid && !overrun;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
            rx_full <= 1'b0;
        end else begin
            if (store) begin
                rx_data <= rx_byte;
                rx_full <= 1'b1;
            end else if (sw_rd) begin
                rx_full <= 1'b0;
            end
        end
    end

    AST_RX_KEEP_OLD: assert property (@(posedge clk) disable iff (rst)
        (active && rx_valid && rx_full && !sw_rd) |=> $stable(rx_data)); // R2

    AST_RX_FULL_SET: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> rx_full); // R8
endmodule

// File: rtl/ovr_tx_track.sv
module ovr_tx_track
    import ovr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          sw_wr,
    input  logic [DW-1:0] sw_wdata,
    input  logic          tx_req,
    input  logic          tx_first,
    input  logic          stop_seen,
    output logic [DW-1:0] tx_byte,
    output logic          tx_empty,
    output logic          underrun
);
    localparam logic [DW-1:0] FILL = {DW{1'b1}};

    logic [DW-1:0] tx_reg;
    tx_dec_t       dec;

    always_comb begin
        dec      = tx_decide(active, tx_empty, tx_first, stop_seen);
        tx_byte  = (dec.src == SRC_FILL) ? FILL : tx_reg;
        underrun = tx_req && dec.err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_reg   <= '0;
            tx_empty <= 1'b1;
        end else begin
            if (sw_wr) begin
                tx_reg   <= sw_wdata;
                tx_empty <= 1'b0;
            end else if (tx_req) begin
                tx_empty <= 1'b1;
            end
        end
    end

    AST_TX_EMPTY_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !sw_wr) |=> tx_empty); // R8

    AST_TX_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        sw_wr |=> !tx_empty); // R8
endmodule

// File: rtl/ovr_flag_unit.sv
module ovr_flag_unit (
    input  logic clk,
    input  logic rst,
    input  logic set_rx,
    input  logic set_tx,
    input  logic clr,
    input  logic ie,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_rx || set_tx) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    always_comb irq = flag && ie;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag); // R6

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag); // R7
endmodule

// File: rtl/i2c_ns_ovr.sv
module i2c_ns_ovr #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          is_slave,
    input  logic          cfg_nostretch,
    input  logic          cfg_err_ie,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          sw_rd,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          rx_nack,
    input  logic          sw_wr,
    input  logic [DW-1:0] sw_wdata,
    input  logic          tx_req,
    input  logic          tx_first,
    input  logic          stop_seen,
    output logic [DW-1:0] tx_byte,
    output logic          tx_empty,
    input  logic          ovr_clr,
    output logic          ovr_flag,
    output logic          irq
);
    logic active;
    logic rx_err;
    logic tx_err;

    always_comb active = is_slave && cfg_nostretch;

    ovr_rx_track #(.DW(DW)) u_rx (
        .clk(clk), .rst(rst), .active(active),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .sw_rd(sw_rd),
        .rx_data(rx_data), .rx_full(rx_full), .overrun(rx_err)
    );

    ovr_tx_track #(.DW(DW)) u_tx (
        .clk(clk), .rst(rst), .active(active),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .tx_req(tx_req), .tx_first(tx_first), .stop_seen(stop_seen),
        .tx_byte(tx_byte), .tx_empty(tx_empty), .underrun(tx_err)
    );

    ovr_flag_unit u_flag (
        .clk(clk), .rst(rst), .set_rx(rx_err), .set_tx(tx_err),
        .clr(ovr_clr), .ie(cfg_err_ie), .flag(ovr_flag), .irq(irq)
    );

    always_comb rx_nack = rx_err;

    AST_NACK_FLAGS: assert property (@(posedge clk) disable iff (rst)
        rx_nack |=> ovr_flag); // R3

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!active && !ovr_flag) |=> !ovr_flag); // R1
endmodule

// File: tb/i2c_ns_ovr_test.sv
`timescale 1ns/1ps
module i2c_ns_ovr_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       is_slave, cfg_nostretch, cfg_err_ie;
    logic       rx_valid, sw_rd, sw_wr, tx_req, tx_first, stop_seen, ovr_clr;
    logic [7:0] rx_byte, sw_wdata;
    logic [7:0] rx_data, tx_byte;
    logic       rx_full, rx_nack, tx_empty, ovr_flag, irq;

    int checks = 0;
    int fails  = 0;

    // model state
    logic [7:0] m_rx, m_tx;
    logic       m_full, m_empty, m_flag;

    always #2.5 clk = ~clk;

    i2c_ns_ovr uut (
        .clk(clk), .rst(rst), .is_slave(is_slave), .cfg_nostretch(cfg_nostretch),
        .cfg_err_ie(cfg_err_ie), .rx_valid(rx_valid), .rx_byte(rx_byte), .sw_rd(sw_rd),
        .rx_data(rx_data), .rx_full(rx_full), .rx_nack(rx_nack), .sw_wr(sw_wr),
        .sw_wdata(sw_wdata), .tx_req(tx_req), .tx_first(tx_first), .stop_seen(stop_seen),
        .tx_byte(tx_byte), .tx_empty(tx_empty), .ovr_clr(ovr_clr), .ovr_flag(ovr_flag),
        .irq(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_active();
        return is_slave && cfg_nostretch;
    endfunction

    // expected byte on a request, per R4/R5/R9
    function automatic logic [7:0] exp_tx_byte();
        if (!exp_active()) return m_tx;
        if (tx_first && stop_seen) return m_empty ? 8'hFF : m_tx;
        return m_empty ? 8'hFF : m_tx;
    endfunction

    function automatic logic exp_tx_err();
        if (!exp_active() || !tx_req) return 1'b0;
        if (tx_first && stop_seen) return 1'b1;
        return m_empty;
    endfunction

    function automatic logic exp_rx_err();
        return exp_active() && rx_valid && m_full && !sw_rd;
    endfunction

    task automatic step(input logic rv, input logic [7:0] rb, input logic rd,
                        input logic wr, input logic [7:0] wd, input logic rq,
                        input logic fst, input logic stp, input logic clr);
        logic rerr, terr;
        logic [7:0] n_rx, n_tx;
        logic n_full, n_empty, n_flag;
        @(negedge clk);
        rx_valid = rv; rx_byte = rb; sw_rd = rd; sw_wr = wr; sw_wdata = wd;
        tx_req = rq; tx_first = fst; stop_seen = stp; ovr_clr = clr;
        #1;
        rerr = exp_rx_err();
        terr = exp_tx_err();
        chk({7'd0, rx_nack}, {7'd0, rerr}, exp_active() ? "R3" : "R9");
        if (rq) chk(tx_byte, exp_tx_byte(),
                    !exp_active() ? "R9" : (fst && stp) ? "R4" : "R5");
        n_rx = m_rx; n_full = m_full; n_tx = m_tx; n_empty = m_empty; n_flag = m_flag;
        if (rv && !rerr) begin n_rx = rb; n_full = 1'b1; end
        else if (rd) n_full = 1'b0;
        if (wr) begin n_tx = wd; n_empty = 1'b0; end
        else if (rq) n_empty = 1'b1;
        if (rerr || terr) n_flag = 1'b1;
        else if (clr) n_flag = 1'b0;
        @(posedge clk);
        #1;
        m_rx = n_rx; m_full = n_full; m_tx = n_tx; m_empty = n_empty; m_flag = n_flag;
        chk(rx_data, m_rx, "R2");
        chk({7'd0, rx_full}, {7'd0, m_full}, "R8");
        chk({7'd0, tx_empty}, {7'd0, m_empty}, "R8");
        chk({7'd0, ovr_flag}, {7'd0, m_flag}, "R6");
        chk({7'd0, irq}, {7'd0, m_flag && cfg_err_ie}, "R7");
    endtask

    task automatic idle();
        step(0, 8'h00, 0, 0, 8'h00, 0, 0, 0, 0);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; is_slave = 1; cfg_nostretch = 0; cfg_err_ie = 0;
        rx_valid = 0; rx_byte = 0; sw_rd = 0; sw_wr = 0; sw_wdata = 0;
        tx_req = 0; tx_first = 0; stop_seen = 0; ovr_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        m_rx = 0; m_tx = 0; m_full = 0; m_empty = 1; m_flag = 0;
        // R8 reset state
        chk({7'd0, rx_full}, 8'd0, "R8");
        chk({7'd0, tx_empty}, 8'd1, "R8");
        chk(rx_data, 8'd0, "R8");
        chk({7'd0, ovr_flag}, 8'd0, "R6");

        // R1/R9: stretch mode allowed -> overwrite, no NACK, no filler
        step(1, 8'h11, 0, 0, 8'h00, 0, 0, 0, 0);
        step(1, 8'h22, 0, 0, 8'h00, 0, 0, 0, 0);
        step(0, 8'h00, 0, 0, 8'h00, 1, 0, 0, 0);
        chk({7'd0, ovr_flag}, 8'd0, "R1");
        step(0, 8'h00, 1, 0, 8'h00, 0, 0, 0, 0);

        // R2/R3: active overrun keeps old byte
        cfg_nostretch = 1;
        step(1, 8'hA1, 0, 0, 8'h00, 0, 0, 0, 0);
        step(1, 8'hB2, 0, 0, 8'h00, 0, 0, 0, 0);
        chk(rx_data, 8'hA1, "R2");
        // R6: set beats clear, then clear
        step(1, 8'hC3, 0, 0, 8'h00, 0, 0, 0, 1);
        step(0, 8'h00, 0, 0, 8'h00, 0, 0, 0, 1);
        // R8: read with strobe in same cycle accepts byte
        step(1, 8'hD4, 1, 0, 8'h00, 0, 0, 0, 0);
        chk(rx_data, 8'hD4, "R8");
        step(0, 8'h00, 1, 0, 8'h00, 0, 0, 0, 1);

        // R5: request while empty -> filler
        step(0, 8'h00, 0, 0, 8'h00, 1, 0, 0, 0);
        step(0, 8'h00, 0, 0, 8'h00, 0, 0, 0, 1);
        // R5: written register, no error
        step(0, 8'h00, 0, 1, 8'h5A, 0, 0, 0, 0);
        step(0, 8'h00, 0, 0, 8'h00, 1, 0, 0, 0);
        chk({7'd0, ovr_flag}, 8'd0, "R5");
        // R4: first after stop with data -> data sent, flag set
        step(0, 8'h00, 0, 1, 8'h3C, 0, 0, 0, 0);
        step(0, 8'h00, 0, 0, 8'h00, 1, 1, 1, 0);
        chk(tx_byte, 8'hFF, "R4");
        step(0, 8'h00, 0, 0, 8'h00, 0, 0, 0, 1);
        // R4: first after stop empty -> filler
        step(0, 8'h00, 0, 0, 8'h00, 1, 1, 1, 0);
        // R7: interrupt follows enable
        cfg_err_ie = 1; idle();
        cfg_err_ie = 0; idle();
        step(0, 8'h00, 0, 0, 8'h00, 0, 0, 0, 1);
        // R8: write and request together, write wins
        step(0, 8'h00, 0, 1, 8'h77, 1, 0, 0, 0);
        step(0, 8'h00, 0, 0, 8'h00, 1, 0, 0, 1);
        // R1: master role never flags
        is_slave = 0;
        step(0, 8'h00, 0, 0, 8'h00, 1, 1, 1, 1);
        step(1, 8'h01, 0, 0, 8'h00, 0, 0, 0, 0);
        step(1, 8'h02, 0, 0, 8'h00, 1, 0, 0, 0);
        chk({7'd0, ovr_flag}, 8'd0, "R1");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            if (i % 200 == 0) begin
                is_slave      = ($urandom() % 8) != 0;
                cfg_nostretch = ($urandom() % 4) != 0;
                cfg_err_ie    = ($urandom() % 2) != 0;
            end
            step(($urandom() % 3) == 0, 8'($urandom()), ($urandom() % 4) == 0,
                 ($urandom() % 4) == 0, 8'($urandom()), ($urandom() % 3) == 0,
                 ($urandom() % 3) == 0, ($urandom() % 3) == 0, ($urandom() % 6) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule